// File: doc/BRIEF.md
# Parallel LSB-First Transmit Scrambler

This block whitens a parallel transmit word before it reaches a serializer that sends bit 0 of each word first. A 15-bit linear feedback shift register generates one keystream bit per serial bit time. The register is unrolled so that a whole word's worth of bit steps, DWIDTH of them, happens in a single clock cycle. Each data bit is XORed with the keystream bit for its own serial slot. The result on the serial line is the same as a bit-serial scrambler running at the line rate.

The register shifts toward index 0, and its feedback enters the top bit. This direction matches a serializer that sends the least significant bit first. The register is loaded from a nonzero seed parameter on a synchronous, active-high reset. It advances only on words marked valid.

The scrambled word is registered, so it appears one cycle after its input, and a matching valid strobe comes with it. Scrambling is its own inverse. A second instance with the same seed, fed the scrambled words, therefore returns the original data.

Top module: `lsbf_scrambler`

## Requirements
- R1: While `rst` is high at a rising clock edge, the keystream register is loaded with the parameter `SEED`, and `out_valid` and `out_data` are cleared to zero. `in_valid` is ignored during reset.
- R2: One bit step maps state s to a new state n, where n[14] = s[1] XOR s[0] and n[13:0] = s[14:1]. This is the polynomial x^15 + x + 1.
- R3: Output bit j equals input bit j XOR bit 0 of the state reached after j single bit steps from the current state. Bit 0 therefore uses the current state's bit 0.
- R4: After each valid word, the register holds the state reached after DWIDTH bit steps. The concatenation of valid output words, taken bit 0 first, equals the output of a bit-serial scrambler with the same seed.
- R5: In a cycle where `in_valid` is low, the register does not advance. On the next clock edge, `out_valid` goes low and `out_data` keeps its previous value.
- R6: The scrambled word and `out_valid` appear at the outputs on the clock edge after the one that samples `in_valid` high.
- R7: The keystream register is never all zeros after reset, so a zero `SEED` is rejected. With all-zero input data, every valid output word has at least one set bit for DWIDTH of 15 or more.
- R8: A second instance with the same `SEED`, driven by `out_valid` and `out_data`, reproduces the original input words one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe; the register advances only when this is high |
| in_data | input | DWIDTH | Parallel word, bit 0 sent first |
| out_valid | output | 1 | Strobe for `out_data`, one cycle after `in_valid` |
| out_data | output | DWIDTH | Scrambled word |

## Verification
The assertions take two things for granted. First, `rst` is held high for at least one clock edge before any checked cycle. Second, `SEED` is nonzero; a zero seed is exactly what the never-zero state property catches. The stimulus starts every run, and the mid-run restart, with several reset cycles. It keeps `in_valid` at known 0 or 1 values, mixing long valid runs with scattered idle cycles. Under this stimulus the hold property and the stable-output property are exercised. The bench uses only nonzero seeds, so the state property has no legitimate failure.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int LFSR_W = 15;

    typedef logic [LFSR_W-1:0] lfsr_t;

    // One serial bit time: shift toward bit 0, feedback of the two low taps into the top.
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[1] ^ s[0], s[LFSR_W-1:1]};
    endfunction

    typedef enum logic {
        WORD_IDLE  = 1'b0,
        WORD_VALID = 1'b1
    } word_kind_e;

endpackage

// File: rtl/scr_keystream.sv
module scr_keystream
    import scr_pkg::*;
#(
    parameter int DWIDTH = 16
) (
    input  lfsr_t              state_i,
    output logic [DWIDTH-1:0]  keystream_o,
    output lfsr_t              next_state_o
);

    // chain[j] is the register contents after j bit steps from state_i
    lfsr_t chain [DWIDTH+1];

    assign chain[0] = state_i;

    genvar j;
    generate
        for (j = 0; j < DWIDTH; j++) begin : g_step
            assign keystream_o[j] = chain[j][0];
            assign chain[j+1]     = lfsr_step(chain[j]);
        end
    endgenerate

    assign next_state_o = chain[DWIDTH];

endmodule

// File: rtl/scr_state.sv
module scr_state
    import scr_pkg::*;
#(
    parameter lfsr_t SEED = 15'h5A3C
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance_i,
    input  lfsr_t next_i,
    output lfsr_t state_o
);

    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (advance_i) begin
            state_q <= next_i;
        end
    end

    assign state_o = state_q;

    // R7: a nonzero seed keeps an invertible register away from zero forever
    p_state_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        state_q != '0)
        else $error("keystream register reached all zeros");

    // R5: no advance on idle cycles
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !advance_i |=> $stable(state_q))
        else $error("keystream register moved on an idle cycle");

endmodule

// File: rtl/scr_outreg.sv
module scr_outreg
    import scr_pkg::*;
#(
    parameter int DWIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DWIDTH-1:0] word_i,
    output logic              out_valid,
    output logic [DWIDTH-1:0] out_data
);

    word_kind_e        kind_q;
    logic [DWIDTH-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= WORD_IDLE;
            data_q <= '0;
        end else begin
            kind_q <= in_valid ? WORD_VALID : WORD_IDLE;
            if (in_valid) begin
                data_q <= word_i;
            end
        end
    end

    assign out_valid = (kind_q == WORD_VALID);
    assign out_data  = data_q;

    // R6: a valid input shows as a valid output one edge later
    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid)
        else $error("valid strobe not delayed by one cycle");

    // R5: an idle input leaves the output word unchanged and invalid
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)))
        else $error("output changed after an idle cycle");

endmodule

// File: rtl/lsbf_scrambler.sv
module lsbf_scrambler
    import scr_pkg::*;
#(
    parameter int    DWIDTH = 16,
    parameter lfsr_t SEED   = 15'h5A3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DWIDTH-1:0] in_data,
    output logic              out_valid,
    output logic [DWIDTH-1:0] out_data
);

    lfsr_t             state;
    lfsr_t             next_state;
    logic [DWIDTH-1:0] keystream;
    logic [DWIDTH-1:0] mixed;

    scr_state #(
        .SEED(SEED)
    ) u_state (
        .clk      (clk),
        .rst      (rst),
        .advance_i(in_valid),
        .next_i   (next_state),
        .state_o  (state)
    );

    scr_keystream #(
        .DWIDTH(DWIDTH)
    ) u_keys (
        .state_i     (state),
        .keystream_o (keystream),
        .next_state_o(next_state)
    );

    assign mixed = in_data ^ keystream;

    scr_outreg #(
        .DWIDTH(DWIDTH)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .word_i   (mixed),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: tb/sim_lsbf_scrambler.sv
module sim_lsbf_scrambler;

    localparam logic [14:0] SEED_A = 15'h5A3C;
    localparam logic [14:0] SEED_B = 15'h0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] din = '0;

    logic        o16_v, o32_v, o64_v, od_v;
    logic [15:0] o16, od;
    logic [31:0] o32;
    logic [63:0] o64;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    lsbf_scrambler #(.DWIDTH(16), .SEED(SEED_A)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din[15:0]),
        .out_valid(o16_v), .out_data(o16));
    lsbf_scrambler #(.DWIDTH(32), .SEED(SEED_B)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din[31:0]),
        .out_valid(o32_v), .out_data(o32));
    lsbf_scrambler #(.DWIDTH(64), .SEED(SEED_A)) u2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din),
        .out_valid(o64_v), .out_data(o64));
    lsbf_scrambler #(.DWIDTH(16), .SEED(SEED_A)) u3 (
        .clk(clk), .rst(rst), .in_valid(o16_v), .in_data(o16),
        .out_valid(od_v), .out_data(od));

    // bit-serial reference, LSB first
    function automatic logic [63:0] ks(input int w, input logic [14:0] s0);
        logic [14:0] s = s0;
        logic [63:0] k = '0;
        for (int i = 0; i < w; i++) begin
            k[i] = s[0];
            s = {s[1] ^ s[0], s[14:1]};
        end
        return k;
    endfunction

    function automatic logic [14:0] adv(input int w, input logic [14:0] s0);
        logic [14:0] s = s0;
        for (int i = 0; i < w; i++) s = {s[1] ^ s[0], s[14:1]};
        return s;
    endfunction

    logic [14:0] st16, st32, st64;
    logic [63:0] e16, e32, e64;
    logic        pv, v1, v2;
    logic [15:0] d1, d2;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_ref();
        st16 = SEED_A; st32 = SEED_B; st64 = SEED_A;
        e16 = '0; e32 = '0; e64 = '0;
        pv = 1'b0; v1 = 1'b0; v2 = 1'b0; d1 = '0; d2 = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; din = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset despite in_valid high
        chk(o16_v == 1'b0 && o16 == '0, "R1 reset u0", {47'd0, o16_v, o16}, '0);
        chk(o32_v == 1'b0 && o32 == '0, "R1 reset u1", {31'd0, o32_v, o32}, '0);
        chk(o64_v == 1'b0 && o64 == '0, "R1 reset u2", o64, '0);
        chk(od_v == 1'b0, "R1 reset u3", od_v, 0);
        rst = 1'b0; in_valid = 1'b0; din = '0;
        clear_ref();
    endtask

    task automatic step(input bit v, input logic [63:0] d, input string tag);
        @(negedge clk);
        // outputs for the previous drive
        chk(o16_v == pv, pv ? "R6 valid u0" : "R5 idle valid u0", o16_v, pv);
        chk(o16 == e16[15:0], pv ? tag : "R5 hold u0", o16, e16[15:0]);
        chk(o32_v == pv && o32 == e32[31:0], pv ? tag : "R5 hold u1", o32, e32[31:0]);
        chk(o64_v == pv && o64 == e64, pv ? tag : "R5 hold u2", o64, e64);
        chk(od_v == v2, "R8 valid chain", od_v, v2);
        if (v2) chk(od == d2, "R8 descramble", od, d2);
        // new drive
        in_valid = v;
        din = d;
        if (v) begin
            e16 = d ^ ks(16, st16); st16 = adv(16, st16);
            e32 = d ^ ks(32, st32); st32 = adv(32, st32);
            e64 = d ^ ks(64, st64); st64 = adv(64, st64);
        end
        pv = v;
        v2 = v1; d2 = d1; v1 = v; d1 = d[15:0];
    endtask

    initial begin
        #2_000_000;
        nfail++; nchk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        clear_ref();
        do_reset();
        // R2: zero data exposes the raw keystream, bit step by bit step
        for (int i = 0; i < 40; i++) begin
            step(1'b1, '0, "R2 keystream");
            if (i > 0) chk(o16 != '0, "R7 nonzero keystream", o16, 1);
        end
        // R3: all ones maps each bit onto its own serial slot
        for (int i = 0; i < 10; i++) step(1'b1, '1, "R3 ones");
        // R4 / R5: random words with scattered idle cycles
        for (int i = 0; i < 160; i++)
            step(($urandom % 4) != 0, {$urandom, $urandom}, "R4 random");
        // R6: isolated single valid words between idles
        for (int i = 0; i < 12; i++)
            step(i[0], {$urandom, $urandom}, "R6 isolated");
        // R1: restart mid-stream, keystream must begin again at the seed
        do_reset();
        for (int i = 0; i < 60; i++)
            step(($urandom % 3) != 0, {$urandom, $urandom}, "R1 R4 after reset");
        step(1'b0, '0, "R5 drain");
        step(1'b0, '0, "R5 drain");
        step(1'b0, '0, "R5 drain");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule